// File: doc/BRIEF.md
# Guarded-code oscillator register file

This block is the register slave that sits between an APB bus and the control logic of a crystal oscillator. Software sets the oscillator enable, its frequency range and a pause (dormant) state. Each of these settings takes effect only when the written value is an exact code word. A write with any other value does not change the setting, so a stray or corrupted store cannot disturb a running clock source. The dormant setting is the one exception: an unknown value there returns it to wake.

A write that holds any unrecognised code sets a sticky error flag. Software clears the flag by writing a one to its bit in the status register. The status register shows the decoded range as a small index, along with the flag and two indications that the oscillator logic returns: enabled and stable. Reads of the control and dormant registers give back the code word that matches the setting now held. Every access completes in its access phase with no wait state and no error response.

Top module: `osc_guard_regs`

## Requirements
- R1: After reset, `osc_en_o` is 0, `osc_range_o` is 0, `osc_dormant_o` is 0 (wake), the error flag is 0, and a status read with both indication inputs low returns 0.
- R2: A write to offset 0x0 with 0xfab in bits 23:12 sets `osc_en_o` to 1. A write there with 0xd1e in those bits sets it to 0. The output changes in the cycle after the access phase.
- R3: A write to offset 0x0 whose bits 11:0 hold 0xaa0, 0xaa1, 0xaa2 or 0xaa3 sets `osc_range_o` to 0, 1, 2 or 3.
- R4: A control write whose enable code and range code are both unrecognised leaves `osc_en_o` and `osc_range_o` unchanged and sets the error flag.
- R5: A control write with one legal code and one illegal code updates only the field whose code is legal, keeps the other field, and sets the error flag.
- R6: A write to offset 0x8 of 0x636f6d61 sets `osc_dormant_o` to 1. A write of 0x77616b65 sets it to 0 without an error. Any other value sets it to 0 and sets the error flag.
- R7: A read of offset 0x4 returns the range index in bits 1:0, `osc_enabled_i` in bit 12, the error flag in bit 24 and `osc_stable_i` in bit 31. All other bits read as 0.
- R8: A write to offset 0x4 with bit 24 set clears the error flag. With bit 24 clear, such a write leaves the flag as it was.
- R9: A read of offset 0x0 returns {8'h00, enable code, range code} for the settings now held (0xfab or 0xd1e, then 0xaa0 plus the index). A read of offset 0x8 returns 0x636f6d61 while dormant and 0x77616b65 while awake.
- R10: `pready_o` is always 1 and `pslverr_o` is always 0. Reads of any offset other than 0x0, 0x4 and 0x8 return 0, and writes to such offsets change no setting and do not touch the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB access phase |
| pwrite_i | input | 1 | APB write when 1 |
| paddr_i | input | ADDR_W | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| pready_o | output | 1 | APB ready, tied high |
| pslverr_o | output | 1 | APB error, tied low |
| osc_enabled_i | input | 1 | Oscillator reports that it is enabled |
| osc_stable_i | input | 1 | Oscillator reports a stable output |
| osc_en_o | output | 1 | Enable control to the oscillator |
| osc_range_o | output | 2 | Frequency range index |
| osc_dormant_o | output | 1 | Pause control, 1 is dormant |

## Verification
A single control write can update one field and raise the error flag at the same clock edge, because the other field in the same word holds a bad code. The bench provokes this with mixed words in both arrangements: a legal enable with a bad range, then a bad enable with a legal range. It judges the result in two ways. The output pins must show the legal field moved and the other held, and a status read must show bit 24 set. The bench also sets the flag, then writes status words with bit 24 low and high, to tell a clear from a hold.

// File: rtl/osc_guard_pkg.sv
package osc_guard_pkg;
  localparam int DATA_W  = 32;
  localparam int FLD_W   = 12;
  localparam int RNG_NUM = 4;
  localparam int RNG_W   = $clog2(RNG_NUM);

  // field placement inside the control word
  localparam int EN_LSB  = 12;
  localparam int RNG_LSB = 0;

  // status bit placement
  localparam int ST_RNG_LSB = 0;
  localparam int ST_EN_BIT  = 12;
  localparam int ST_ERR_BIT = 24;
  localparam int ST_STB_BIT = 31;

  localparam logic [FLD_W-1:0]  EN_ON     = 12'hfab;
  localparam logic [FLD_W-1:0]  EN_OFF    = 12'hd1e;
  localparam logic [FLD_W-1:0]  RNG_BASE  = 12'haa0;
  localparam logic [DATA_W-1:0] DRM_PAUSE = 32'h636f6d61;
  localparam logic [DATA_W-1:0] DRM_WAKE  = 32'h77616b65;

  localparam int OFF_CTRL = 'h0;
  localparam int OFF_STAT = 'h4;
  localparam int OFF_DRM  = 'h8;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_STAT,
    SEL_DRM
  } reg_sel_e;

  typedef struct packed {
    logic             en_ok;
    logic             en_val;
    logic             rng_ok;
    logic [RNG_W-1:0] rng_val;
    logic             drm_ok;
    logic             drm_val;
  } code_dec_t;
endpackage

// File: rtl/osc_code_decode.sv
module osc_code_decode
  import osc_guard_pkg::*;
(
  input  logic [DATA_W-1:0] wdata_i,
  output code_dec_t         dec_o
);
  logic [FLD_W-1:0]   en_code;
  logic [FLD_W-1:0]   rng_code;
  logic [RNG_NUM-1:0] rng_hit;
  logic [RNG_W-1:0]   rng_idx;

  assign en_code  = wdata_i[EN_LSB +: FLD_W];
  assign rng_code = wdata_i[RNG_LSB +: FLD_W];

  // one comparator per legal range code
  for (genvar k = 0; k < RNG_NUM; k++) begin : g_rng
    assign rng_hit[k] = (rng_code == RNG_BASE + FLD_W'(k));
  end

  always_comb begin
    rng_idx = '0;
    for (int k = 0; k < RNG_NUM; k++) begin
      if (rng_hit[k]) rng_idx = RNG_W'(k);
    end
  end

  always_comb begin
    dec_o.en_ok   = (en_code == EN_ON) || (en_code == EN_OFF);
    dec_o.en_val  = (en_code == EN_ON);
    dec_o.rng_ok  = |rng_hit;
    dec_o.rng_val = rng_idx;
    dec_o.drm_ok  = (wdata_i == DRM_PAUSE) || (wdata_i == DRM_WAKE);
    dec_o.drm_val = (wdata_i == DRM_PAUSE);
  end

  always_comb begin
    a_r3_range_unique: assert ($onehot0(rng_hit))
      else $error("a_r3_range_unique: more than one range code matched");
  end
endmodule

// File: rtl/osc_guard_field.sv
module osc_guard_field #(
  parameter int           W   = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         upd_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_q <= RST;
    else if (upd_i) q_q <= d_i;
  end

  assign q_o = q_q;

  a_r4_hold_no_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(q_o))
    else $error("a_r4_hold_no_update: field moved without a legal write");

  a_r2_load_on_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> (q_o == $past(d_i)))
    else $error("a_r2_load_on_update: field did not take the decoded value");
endmodule

// File: rtl/osc_err_flag.sv
module osc_err_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic err_o
);
  logic err_q;

  // a set wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     err_q <= 1'b0;
    else if (set_i)  err_q <= 1'b1;
    else if (clr_i)  err_q <= 1'b0;
  end

  assign err_o = err_q;

  a_r4_err_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> err_o)
    else $error("a_r4_err_sets: flag not raised by a bad code");

  a_r8_err_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !err_o)
    else $error("a_r8_err_clears: flag not cleared by write-one");

  a_r8_err_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !set_i) |=> $stable(err_o))
    else $error("a_r8_err_holds: flag changed with no cause");
endmodule

// File: rtl/osc_guard_regs.sv
module osc_guard_regs
  import osc_guard_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  output logic              pready_o,
  output logic              pslverr_o,
  input  logic              osc_enabled_i,
  input  logic              osc_stable_i,
  output logic              osc_en_o,
  output logic [RNG_W-1:0]  osc_range_o,
  output logic              osc_dormant_o
);
  reg_sel_e  sel;
  code_dec_t dec;
  logic      wr_acc;
  logic      ctrl_wr, stat_wr, drm_wr;
  logic      en_upd, rng_upd;
  logic      err_set, err_clr, err_flag;

  always_comb begin
    if      (paddr_i == ADDR_W'(OFF_CTRL)) sel = SEL_CTRL;
    else if (paddr_i == ADDR_W'(OFF_STAT)) sel = SEL_STAT;
    else if (paddr_i == ADDR_W'(OFF_DRM))  sel = SEL_DRM;
    else                                   sel = SEL_NONE;
  end

  assign wr_acc  = psel_i && penable_i && pwrite_i;
  assign ctrl_wr = wr_acc && (sel == SEL_CTRL);
  assign stat_wr = wr_acc && (sel == SEL_STAT);
  assign drm_wr  = wr_acc && (sel == SEL_DRM);

  osc_code_decode u_dec (
    .wdata_i (pwdata_i),
    .dec_o   (dec)
  );

  assign en_upd  = ctrl_wr && dec.en_ok;
  assign rng_upd = ctrl_wr && dec.rng_ok;

  osc_guard_field #(.W(1), .RST(1'b0)) u_en (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (en_upd),
    .d_i    (dec.en_val),
    .q_o    (osc_en_o)
  );

  osc_guard_field #(.W(RNG_W), .RST('0)) u_rng (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (rng_upd),
    .d_i    (dec.rng_val),
    .q_o    (osc_range_o)
  );

  // any dormant write loads: an unknown value decodes to wake
  osc_guard_field #(.W(1), .RST(1'b0)) u_drm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (drm_wr),
    .d_i    (dec.drm_val),
    .q_o    (osc_dormant_o)
  );

  assign err_set = (ctrl_wr && !(dec.en_ok && dec.rng_ok)) ||
                   (drm_wr && !dec.drm_ok);
  assign err_clr = stat_wr && pwdata_i[ST_ERR_BIT];

  osc_err_flag u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (err_set),
    .clr_i  (err_clr),
    .err_o  (err_flag)
  );

  always_comb begin
    prdata_o = '0;
    unique case (sel)
      SEL_CTRL: begin
        prdata_o[EN_LSB +: FLD_W]  = osc_en_o ? EN_ON : EN_OFF;
        prdata_o[RNG_LSB +: FLD_W] = RNG_BASE + FLD_W'(osc_range_o);
      end
      SEL_STAT: begin
        prdata_o[ST_RNG_LSB +: RNG_W] = osc_range_o;
        prdata_o[ST_EN_BIT]           = osc_enabled_i;
        prdata_o[ST_ERR_BIT]          = err_flag;
        prdata_o[ST_STB_BIT]          = osc_stable_i;
      end
      SEL_DRM:  prdata_o = osc_dormant_o ? DRM_PAUSE : DRM_WAKE;
      default:  prdata_o = '0;
    endcase
  end

  assign pready_o  = 1'b1;
  assign pslverr_o = 1'b0;

  a_r10_no_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psel_i |-> (pready_o && !pslverr_o))
    else $error("a_r10_no_stall: wait or error response seen");

  a_r6_wake_fallback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drm_wr && (pwdata_i != DRM_PAUSE)) |=> !osc_dormant_o)
    else $error("a_r6_wake_fallback: dormant held after non-pause write");

  a_r2_enable_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && (pwdata_i[EN_LSB +: FLD_W] == EN_ON)) |=> osc_en_o)
    else $error("a_r2_enable_on: enable code did not take effect");

  a_r10_stray_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_acc && (sel == SEL_NONE)) |=>
      ($stable(osc_en_o) && $stable(osc_range_o) && $stable(osc_dormant_o)))
    else $error("a_r10_stray_write: undefined offset changed a setting");
endmodule

// File: tb/osc_guard_regs_tb.sv
`timescale 1ns/1ps
module osc_guard_regs_tb;
  localparam int ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [ADDR_W-1:0] paddr = '0;
  logic [31:0]       pwdata = '0;
  logic [31:0]       prdata;
  logic              pready, pslverr;
  logic              enabled_in = 1'b0, stable_in = 1'b0;
  logic              en_o, drm_o;
  logic [1:0]        rng_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  osc_guard_regs #(.ADDR_W(ADDR_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .pready_o(pready), .pslverr_o(pslverr),
    .osc_enabled_i(enabled_in), .osc_stable_i(stable_in),
    .osc_en_o(en_o), .osc_range_o(rng_o), .osc_dormant_o(drm_o)
  );

  function automatic logic [31:0] stat_word(logic stb, logic err, logic en, logic [1:0] r);
    return {stb, 6'b0, err, 11'b0, en, 10'b0, r};
  endfunction

  function automatic logic [31:0] ctrl_word(logic en, logic [1:0] r);
    return {8'h00, (en ? 12'hfab : 12'hd1e), 12'haa0 + {10'b0, r}};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_pins(string req, logic en, logic [1:0] r, logic d);
    @(negedge clk);
    check(req, {29'b0, en_o, rng_o}, {29'b0, en, r});
    check(req, {31'b0, drm_o}, {31'b0, d});
  endtask

  task automatic apb_write(logic [ADDR_W-1:0] a, logic [31:0] d);
    @(posedge clk); #1;
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
    @(posedge clk); #1;
    penable = 1'b1;
    @(posedge clk); #1;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_read(logic [ADDR_W-1:0] a, logic [31:0] exp, string req);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    @(posedge clk); #1;
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
    @(posedge clk); #1;
    penable = 1'b1;
    @(posedge clk); #1;
    psel = 1'b0; penable = 1'b0;
  endtask

  // monitor: compare read data in the access phase against the scoreboard
  always @(negedge clk) begin
    if (psel && penable && !pwrite) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL scoreboard: read with no expected item, actual %h expected none", prdata);
      end else begin
        check(tag_q.pop_front(), prdata, exp_q.pop_front());
      end
      check("R10 ready/error", {30'b0, pready, pslverr}, 32'h2);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    check_pins("R1 reset pins", 1'b0, 2'd0, 1'b0);
    apb_read(8'h04, 32'h0, "R1 reset status");

    // R2 R3 legal control write
    apb_write(8'h00, 32'h00fabaa2);
    check_pins("R2 R3 enable+range", 1'b1, 2'd2, 1'b0);
    apb_read(8'h00, ctrl_word(1'b1, 2'd2), "R9 ctrl readback");
    apb_read(8'h04, stat_word(1'b0, 1'b0, 1'b0, 2'd2), "R7 status no error");

    // R3 every range code
    for (int k = 0; k < 4; k++) begin
      apb_write(8'h00, {8'h00, 12'hfab, 12'haa0 + 12'(k)});
      check_pins("R3 range sweep", 1'b1, 2'(k), 1'b0);
    end

    // R2 disable
    apb_write(8'h00, 32'h00d1eaa1);
    check_pins("R2 disable", 1'b0, 2'd1, 1'b0);
    apb_read(8'h00, ctrl_word(1'b0, 2'd1), "R9 ctrl readback off");

    // R4 both codes illegal
    apb_write(8'h00, 32'h00123456);
    check_pins("R4 illegal hold", 1'b0, 2'd1, 1'b0);
    apb_read(8'h04, stat_word(1'b0, 1'b1, 1'b0, 2'd1), "R4 error set");

    // R8 write zero keeps, write one clears
    apb_write(8'h04, 32'hfeffffff);
    apb_read(8'h04, stat_word(1'b0, 1'b1, 1'b0, 2'd1), "R8 bit24 low holds");
    check_pins("R8 status write no side effect", 1'b0, 2'd1, 1'b0);
    apb_write(8'h04, 32'h01000000);
    apb_read(8'h04, stat_word(1'b0, 1'b0, 1'b0, 2'd1), "R8 bit24 high clears");

    // R5 mixed: legal enable, bad range
    apb_write(8'h00, 32'h00fabab0);
    check_pins("R5 legal enable only", 1'b1, 2'd1, 1'b0);
    apb_read(8'h04, stat_word(1'b0, 1'b1, 1'b0, 2'd1), "R5 error on mixed");
    apb_write(8'h04, 32'h01000000);
    // R5 mixed: bad enable, legal range
    apb_write(8'h00, 32'h00000aa3);
    check_pins("R5 legal range only", 1'b1, 2'd3, 1'b0);
    apb_read(8'h04, stat_word(1'b0, 1'b1, 1'b0, 2'd3), "R5 error on mixed 2");
    apb_write(8'h04, 32'h01000000);

    // R6 dormant
    apb_write(8'h08, 32'h636f6d61);
    check_pins("R6 pause", 1'b1, 2'd3, 1'b1);
    apb_read(8'h08, 32'h636f6d61, "R9 dormant readback");
    apb_write(8'h08, 32'h77616b65);
    check_pins("R6 wake", 1'b1, 2'd3, 1'b0);
    apb_read(8'h08, 32'h77616b65, "R9 wake readback");
    apb_read(8'h04, stat_word(1'b0, 1'b0, 1'b0, 2'd3), "R6 wake no error");
    apb_write(8'h08, 32'h636f6d61);
    apb_write(8'h08, 32'hdeadbeef);
    check_pins("R6 bad code falls to wake", 1'b1, 2'd3, 1'b0);
    apb_read(8'h04, stat_word(1'b0, 1'b1, 1'b0, 2'd3), "R6 bad code error");
    apb_write(8'h04, 32'h01000000);

    // R7 indication inputs
    stable_in = 1'b1; enabled_in = 1'b1;
    apb_read(8'h04, stat_word(1'b1, 1'b0, 1'b1, 2'd3), "R7 both indications");
    stable_in = 1'b0;
    apb_read(8'h04, stat_word(1'b0, 1'b0, 1'b1, 2'd3), "R7 enabled only");

    // R10 undefined offsets
    apb_write(8'h0c, 32'h00d1eaa0);
    apb_write(8'h10, 32'h12345678);
    check_pins("R10 stray write no effect", 1'b1, 2'd3, 1'b0);
    apb_read(8'h0c, 32'h0, "R10 undefined read");
    apb_read(8'h10, 32'h0, "R10 undefined read 2");
    apb_read(8'h04, stat_word(1'b0, 1'b0, 1'b1, 2'd3), "R10 stray write no error");

    repeat (2) @(posedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule